// File: doc/BRIEF.md
# Vector Fragment Divergence Controller

This block steers control flow for a group of virtual processors (VPs) that share one instruction issue stream inside a single vector-thread lane. It holds the current fetch PC and the active VP mask. For every vector branch it reduces the per-VP taken bits to one outcome. A uniform outcome moves the whole group together. A mixed outcome splits the group: the taken VPs are parked as a pending fragment in a small buffer, and issue carries on down the fall-through path with the VPs that did not take the branch.

Parked fragments come back in two ways. The first is reconvergence: the running fragment reaches a PC at which a pending fragment waits, and the two masks join. The second is a stop: the running fragment ends, and the pending fragment with the lowest PC is resumed. When a new fragment targets a PC that already has a pending entry, the two are merged into that one entry, so the buffer never holds two entries with the same PC. When no fragment remains after a stop, the block goes idle and raises done. The block handles one event per cycle. Its state is visible on the outputs from the cycle after the event.

Top module: `vfrag_ctrl`

## Requirements
- R1: After reset, pc_o is 0, mask_o is all zeros, done_o is 1 and stall_o is 0.
- R2: While idle (done_o = 1), start_i with a non-zero start_mask_i loads pc_o and mask_o and clears done_o on the next cycle. A start while running has no effect.
- R3: While running, at most one event is taken per cycle, with priority stop_i over br_valid_i over adv_i. adv_i sets pc_o to pc_o + 1 and keeps the mask, apart from reconvergence (R8).
- R4: Bits of br_taken_i for VPs that are not in mask_o are ignored.
- R5: A branch that no active VP takes sets pc_o to pc_o + 1 with the mask unchanged.
- R6: A branch that every active VP takes sets pc_o to br_target_i with the mask unchanged, and creates no pending fragment.
- R7: A mixed branch stores a pending fragment holding br_target_i and the taken active VPs. pc_o becomes pc_o + 1 and mask_o becomes the active VPs that did not take the branch. If br_target_i equals pc_o + 1, no fragment is stored and the mask stays whole.
- R8: When the new PC after an advance or a branch equals the PC of a pending fragment, that fragment's mask is ORed into the new mask and the fragment is removed in the same cycle.
- R9: A new fragment whose target PC is already pending is ORed into that entry and uses no new slot.
- R10: On stop_i the pending fragment with the lowest PC is removed, and its PC and mask become current. If none is pending, done_o rises, mask_o becomes 0 and pc_o holds.
- R11: stall_o is high in the same cycle as a mixed branch that needs a new slot while the buffer is full. During a stall, pc_o, mask_o and the buffer stay unchanged.
- R12: While idle, stop_i, br_valid_i and adv_i have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new group while idle |
| start_pc_i | input | PC_W | Starting PC |
| start_mask_i | input | NUM_VP | Starting active mask |
| stop_i | input | 1 | Current fragment has ended |
| br_valid_i | input | 1 | Vector branch resolved this cycle |
| br_target_i | input | PC_W | Branch target PC |
| br_taken_i | input | NUM_VP | Per-VP taken bits |
| adv_i | input | 1 | Plain sequential instruction issued |
| pc_o | output | PC_W | Current fetch PC |
| mask_o | output | NUM_VP | Current active VP mask |
| done_o | output | 1 | Idle, no fragment left |
| stall_o | output | 1 | Branch held, buffer full |

## Verification
Some properties are checked on every cycle. An idle block has an empty mask, a running block never does, and a stall freezes the PC and the mask. A branch taken by no VP advances the PC by one, and after a mixed split none of the taken VPs remain in the active mask. Other behaviour depends on what the buffer holds, and only the bench scenarios can show it. These are the choice of the lowest pending PC on a stop, the merge of fragments that share a target, the joining of masks when the PC reaches a pending entry, and the stall that clears once a merge needs no new slot.

// File: rtl/vfrag_pkg.sv
package vfrag_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_START,
    ACT_STOP,
    ACT_BR,
    ACT_ADV
  } act_e;
endpackage

// File: rtl/vfrag_resolve.sv
module vfrag_resolve #(
  parameter int NUM_VP = 8
) (
  input  logic [NUM_VP-1:0] mask_i,
  input  logic [NUM_VP-1:0] taken_i,
  output logic [NUM_VP-1:0] taken_eff_o,
  output logic              none_o,
  output logic              all_o,
  output logic              mixed_o
);
  // Taken bits of inactive VPs are ignored.
  assign taken_eff_o = mask_i & taken_i;
  assign none_o      = ~|taken_eff_o;
  assign all_o       = (taken_eff_o == mask_i);
  assign mixed_o     = ~none_o & ~all_o;
endmodule

// File: rtl/vfrag_minsel.sv
module vfrag_minsel #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]           vld_i,
  input  logic [DEPTH-1:0][PC_W-1:0] pc_i,
  output logic                       any_o,
  output logic [IDX_W-1:0]           idx_o
);
  logic [PC_W-1:0] best;

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    best  = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_i[i] && (!any_o || pc_i[i] < best)) begin
        any_o = 1'b1;
        best  = pc_i[i];
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vfrag_buf.sv
module vfrag_buf #(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 16,
  parameter int NUM_VP = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   look_pc_i,
  output logic              look_hit_o,
  output logic [NUM_VP-1:0] look_mask_o,
  input  logic              rm_en_i,
  input  logic [PC_W-1:0]   tgt_pc_i,
  output logic              tgt_hit_o,
  input  logic              ins_en_i,
  input  logic [NUM_VP-1:0] ins_mask_i,
  input  logic              pop_en_i,
  output logic [PC_W-1:0]   pop_pc_o,
  output logic [NUM_VP-1:0] pop_mask_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [DEPTH-1:0]             vld_q;
  logic [DEPTH-1:0][PC_W-1:0]   pc_q;
  logic [DEPTH-1:0][NUM_VP-1:0] mask_q;

  logic [IDX_W-1:0] look_idx, tgt_idx, free_idx, min_idx;
  logic             free_any, min_any;

  always_comb begin
    look_hit_o = 1'b0;
    look_idx   = '0;
    tgt_hit_o  = 1'b0;
    tgt_idx    = '0;
    free_any   = 1'b0;
    free_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i] && pc_q[i] == look_pc_i) begin
        look_hit_o = 1'b1;
        look_idx   = IDX_W'(i);
      end
      if (vld_q[i] && pc_q[i] == tgt_pc_i) begin
        tgt_hit_o = 1'b1;
        tgt_idx   = IDX_W'(i);
      end
      if (!vld_q[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  vfrag_minsel #(.DEPTH(DEPTH), .PC_W(PC_W)) i_minsel (
    .vld_i (vld_q),
    .pc_i  (pc_q),
    .any_o (min_any),
    .idx_o (min_idx)
  );

  assign look_mask_o = mask_q[look_idx];
  assign pop_pc_o    = pc_q[min_idx];
  assign pop_mask_o  = mask_q[min_idx];
  assign full_o      = ~free_any;
  assign empty_o     = ~min_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      pc_q   <= '0;
      mask_q <= '0;
    end else begin
      if (ins_en_i) begin
        if (tgt_hit_o) begin
          mask_q[tgt_idx] <= mask_q[tgt_idx] | ins_mask_i;
        end else if (free_any) begin
          vld_q[free_idx]  <= 1'b1;
          pc_q[free_idx]   <= tgt_pc_i;
          mask_q[free_idx] <= ins_mask_i;
        end
      end
      if (rm_en_i && look_hit_o) vld_q[look_idx] <= 1'b0;
      if (pop_en_i && min_any)   vld_q[min_idx]  <= 1'b0;
    end
  end
endmodule

// File: rtl/vfrag_ctrl.sv
module vfrag_ctrl
  import vfrag_pkg::*;
#(
  parameter int NUM_VP = 8,
  parameter int PC_W   = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PC_W-1:0]   start_pc_i,
  input  logic [NUM_VP-1:0] start_mask_i,
  input  logic              stop_i,
  input  logic              br_valid_i,
  input  logic [PC_W-1:0]   br_target_i,
  input  logic [NUM_VP-1:0] br_taken_i,
  input  logic              adv_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [NUM_VP-1:0] mask_o,
  output logic              done_o,
  output logic              stall_o
);
  logic              run_q, run_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [NUM_VP-1:0] mask_q, mask_d;
  act_e              act;

  logic [NUM_VP-1:0] taken_eff;
  logic              br_none, br_all, br_mixed;
  logic [PC_W-1:0]   seq_pc, look_pc;
  logic              br_split, stall, merge_en;

  logic              look_hit, tgt_hit, buf_full, buf_empty;
  logic [NUM_VP-1:0] look_mask, pop_mask;
  logic [PC_W-1:0]   pop_pc;

  vfrag_resolve #(.NUM_VP(NUM_VP)) i_resolve (
    .mask_i      (mask_q),
    .taken_i     (br_taken_i),
    .taken_eff_o (taken_eff),
    .none_o      (br_none),
    .all_o       (br_all),
    .mixed_o     (br_mixed)
  );

  always_comb begin
    if (!run_q)          act = (start_i && |start_mask_i) ? ACT_START : ACT_NONE;
    else if (stop_i)     act = ACT_STOP;
    else if (br_valid_i) act = ACT_BR;
    else if (adv_i)      act = ACT_ADV;
    else                 act = ACT_NONE;
  end

  assign seq_pc   = pc_q + PC_W'(1);
  // A split whose target is the next PC rejoins at once: keep the group whole.
  assign br_split = (act == ACT_BR) && br_mixed && (br_target_i != seq_pc);
  assign stall    = br_split && buf_full && !tgt_hit;
  assign look_pc  = (act == ACT_BR && br_all) ? br_target_i : seq_pc;
  assign merge_en = ((act == ACT_BR) && !stall) || (act == ACT_ADV);

  vfrag_buf #(.DEPTH(DEPTH), .PC_W(PC_W), .NUM_VP(NUM_VP)) i_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .look_pc_i   (look_pc),
    .look_hit_o  (look_hit),
    .look_mask_o (look_mask),
    .rm_en_i     (merge_en),
    .tgt_pc_i    (br_target_i),
    .tgt_hit_o   (tgt_hit),
    .ins_en_i    (br_split && !stall),
    .ins_mask_i  (taken_eff),
    .pop_en_i    (act == ACT_STOP),
    .pop_pc_o    (pop_pc),
    .pop_mask_o  (pop_mask),
    .full_o      (buf_full),
    .empty_o     (buf_empty)
  );

  always_comb begin
    run_d  = run_q;
    pc_d   = pc_q;
    mask_d = mask_q;
    unique case (act)
      ACT_START: begin
        run_d  = 1'b1;
        pc_d   = start_pc_i;
        mask_d = start_mask_i;
      end
      ACT_STOP: begin
        if (buf_empty) begin
          run_d  = 1'b0;
          mask_d = '0;
        end else begin
          pc_d   = pop_pc;
          mask_d = pop_mask;
        end
      end
      ACT_BR: begin
        if (!stall) begin
          if (br_all)        pc_d = br_target_i;
          else if (br_split) begin
            pc_d   = seq_pc;
            mask_d = mask_q & ~taken_eff;
          end else           pc_d = seq_pc;
        end
      end
      ACT_ADV: pc_d = seq_pc;
      default: ;
    endcase
    if (merge_en && look_hit) mask_d = mask_d | look_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pc_q   <= '0;
      mask_q <= '0;
    end else begin
      run_q  <= run_d;
      pc_q   <= pc_d;
      mask_q <= mask_d;
    end
  end

  assign pc_o    = pc_q;
  assign mask_o  = mask_q;
  assign done_o  = ~run_q;
  assign stall_o = stall;

  // br_none is folded into the default fall-through path
  logic unused_none;
  assign unused_none = br_none;
endmodule

// File: rtl/vfrag_ctrl_chk.sv
module vfrag_ctrl_chk #(
  parameter int NUM_VP = 8,
  parameter int PC_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              br_valid_i,
  input logic [PC_W-1:0]   br_target_i,
  input logic [NUM_VP-1:0] br_taken_i,
  input logic [PC_W-1:0]   pc_o,
  input logic [NUM_VP-1:0] mask_o,
  input logic              done_o,
  input logic              stall_o,
  input logic              buf_full,
  input logic              buf_empty
);
  logic br_act, br_mix;
  assign br_act = !done_o && !stop_i && br_valid_i;
  assign br_mix = ((br_taken_i & mask_o) != '0) && ((br_taken_i & mask_o) != mask_o)
                  && (br_target_i != pc_o + PC_W'(1));

  a_r10_idle_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> mask_o == '0);

  a_r2_live_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> mask_o != '0);

  a_r11_stall_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> buf_full);

  a_r11_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(pc_o) && $stable(mask_o));

  a_r5_none_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_act && ((br_taken_i & mask_o) == '0) |=> pc_o == $past(pc_o) + PC_W'(1));

  a_r7_split_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_act && br_mix && !stall_o |=> (mask_o & $past(br_taken_i & mask_o)) == '0);

  a_r10_last_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o && stop_i && buf_empty |=> done_o);
endmodule

bind vfrag_ctrl vfrag_ctrl_chk #(.NUM_VP(NUM_VP), .PC_W(PC_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stop_i      (stop_i),
  .br_valid_i  (br_valid_i),
  .br_target_i (br_target_i),
  .br_taken_i  (br_taken_i),
  .pc_o        (pc_o),
  .mask_o      (mask_o),
  .done_o      (done_o),
  .stall_o     (stall_o),
  .buf_full    (buf_full),
  .buf_empty   (buf_empty)
);

// File: tb/test_vfrag_ctrl.sv
`timescale 1ns/1ps
module test_vfrag_ctrl;
  localparam int NUM_VP = 8;
  localparam int PC_W   = 16;
  localparam int DEPTH  = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [PC_W-1:0]   start_pc_i = '0;
  logic [NUM_VP-1:0] start_mask_i = '0;
  logic              stop_i = 1'b0;
  logic              br_valid_i = 1'b0;
  logic [PC_W-1:0]   br_target_i = '0;
  logic [NUM_VP-1:0] br_taken_i = '0;
  logic              adv_i = 1'b0;
  logic [PC_W-1:0]   pc_o;
  logic [NUM_VP-1:0] mask_o;
  logic              done_o, stall_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  logic [PC_W-1:0]   exp_pc_q[$];
  logic [NUM_VP-1:0] exp_mask_q[$];
  logic              exp_done_q[$];
  string             exp_tag_q[$];

  always #10 clk = ~clk;

  vfrag_ctrl #(.NUM_VP(NUM_VP), .PC_W(PC_W), .DEPTH(DEPTH)) i_vfrag_ctrl (
    .clk_i (clk), .rst_ni (rst_ni),
    .start_i (start_i), .start_pc_i (start_pc_i), .start_mask_i (start_mask_i),
    .stop_i (stop_i), .br_valid_i (br_valid_i), .br_target_i (br_target_i),
    .br_taken_i (br_taken_i), .adv_i (adv_i),
    .pc_o (pc_o), .mask_o (mask_o), .done_o (done_o), .stall_o (stall_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: apply one event, check stall now, queue the state expected after the edge.
  task automatic step(input string tag, input logic s, input logic [PC_W-1:0] spc,
                      input logic [NUM_VP-1:0] smask, input logic stp, input logic bv,
                      input logic [PC_W-1:0] tgt, input logic [NUM_VP-1:0] tk, input logic adv,
                      input logic e_stall, input logic [PC_W-1:0] e_pc,
                      input logic [NUM_VP-1:0] e_mask, input logic e_done);
    @(negedge clk);
    start_i = s; start_pc_i = spc; start_mask_i = smask; stop_i = stp;
    br_valid_i = bv; br_target_i = tgt; br_taken_i = tk; adv_i = adv;
    #1;
    chk(tag, "stall", 32'(stall_o), 32'(e_stall));
    exp_pc_q.push_back(e_pc);
    exp_mask_q.push_back(e_mask);
    exp_done_q.push_back(e_done);
    exp_tag_q.push_back(tag);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (exp_tag_q.size() > 0) begin
      string t;
      t = exp_tag_q.pop_front();
      chk(t, "pc",   32'(pc_o),   32'(exp_pc_q.pop_front()));
      chk(t, "mask", 32'(mask_o), 32'(exp_mask_q.pop_front()));
      chk(t, "done", 32'(done_o), 32'(exp_done_q.pop_front()));
    end
  end

  initial begin
    #(20 * 5000);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", "pc", 32'(pc_o), 0);
    chk("R1", "mask", 32'(mask_o), 0);
    chk("R1", "done", 32'(done_o), 1);
    chk("R1", "stall", 32'(stall_o), 0);
    rst_ni = 1'b1;
    //   tag    st  spc      smask  stp br  tgt      taken  adv  stall pc       mask   done
    step("R2",  1, 16'h0010, 8'hFF, 0, 0, 16'h0000, 8'h00, 0,   0, 16'h0010, 8'hFF, 0);
    step("R2",  1, 16'h0500, 8'h01, 0, 0, 16'h0000, 8'h00, 0,   0, 16'h0010, 8'hFF, 0);
    step("R3",  0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h00, 1,   0, 16'h0011, 8'hFF, 0);
    step("R5",  0, 16'h0000, 8'h00, 0, 1, 16'h0040, 8'h00, 0,   0, 16'h0012, 8'hFF, 0);
    step("R6",  0, 16'h0000, 8'h00, 0, 1, 16'h0020, 8'hFF, 0,   0, 16'h0020, 8'hFF, 0);
    step("R7",  0, 16'h0000, 8'h00, 0, 1, 16'h0030, 8'h0F, 0,   0, 16'h0021, 8'hF0, 0);
    step("R9",  0, 16'h0000, 8'h00, 0, 1, 16'h0030, 8'h10, 0,   0, 16'h0022, 8'hE0, 0);
    step("R7",  0, 16'h0000, 8'h00, 0, 1, 16'h0028, 8'h20, 0,   0, 16'h0023, 8'hC0, 0);
    step("R11", 0, 16'h0000, 8'h00, 0, 1, 16'h0060, 8'h40, 0,   1, 16'h0023, 8'hC0, 0);
    step("R4",  0, 16'h0000, 8'h00, 0, 1, 16'h0030, 8'h4F, 0,   0, 16'h0024, 8'h80, 0);
    step("R10", 0, 16'h0000, 8'h00, 1, 0, 16'h0000, 8'h00, 0,   0, 16'h0028, 8'h20, 0);
    step("R6",  0, 16'h0000, 8'h00, 0, 1, 16'h002F, 8'h20, 0,   0, 16'h002F, 8'h20, 0);
    step("R8",  0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h00, 1,   0, 16'h0030, 8'h7F, 0);
    step("R10", 0, 16'h0000, 8'h00, 1, 0, 16'h0000, 8'h00, 0,   0, 16'h0030, 8'h00, 1);
    step("R12", 0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h00, 1,   0, 16'h0030, 8'h00, 1);
    step("R12", 0, 16'h0000, 8'h00, 1, 1, 16'h0099, 8'hFF, 0,   0, 16'h0030, 8'h00, 1);
    step("R2",  1, 16'h0100, 8'h03, 0, 0, 16'h0000, 8'h00, 0,   0, 16'h0100, 8'h03, 0);
    step("R7",  0, 16'h0000, 8'h00, 0, 1, 16'h0101, 8'h01, 0,   0, 16'h0101, 8'h03, 0);
    step("R7",  0, 16'h0000, 8'h00, 1, 0, 16'h0000, 8'h00, 0,   0, 16'h0101, 8'h00, 1);
    step("R2",  1, 16'h0200, 8'h0F, 0, 0, 16'h0000, 8'h00, 0,   0, 16'h0200, 8'h0F, 0);
    step("R7",  0, 16'h0000, 8'h00, 0, 1, 16'h0210, 8'h03, 0,   0, 16'h0201, 8'h0C, 0);
    step("R8",  0, 16'h0000, 8'h00, 0, 1, 16'h0210, 8'h0C, 0,   0, 16'h0210, 8'h0F, 0);
    step("R8",  0, 16'h0000, 8'h00, 1, 0, 16'h0000, 8'h00, 0,   0, 16'h0210, 8'h00, 1);
    step("R2",  1, 16'h0300, 8'h0F, 0, 0, 16'h0000, 8'h00, 0,   0, 16'h0300, 8'h0F, 0);
    step("R3",  0, 16'h0000, 8'h00, 1, 1, 16'h0350, 8'h0F, 1,   0, 16'h0300, 8'h00, 1);
    @(negedge clk);
    start_i = 0; stop_i = 0; br_valid_i = 0; adv_i = 0;
    repeat (3) @(negedge clk);
    ended = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule